// File: doc/BRIEF.md
# Escaped-Delimiter Serial Command Framer

This block sits between a UART byte receiver/transmitter pair and an internal byte-addressed register memory. Received bytes arrive as a valid/data stream. The block finds frames in that stream, removes the escape sequences, and turns each frame into either a run of memory writes or a read. A read is answered with a response frame on a transmit byte stream that has a ready handshake. Escape sequences are inserted into that response wherever a payload byte collides with a reserved value.

Three byte values are reserved:

- 0xFE opens a frame.
- 0xFF closes a frame.
- 0xFD escapes the next byte. Inside a frame, 0xFD followed by 0x00, 0x01 or 0x02 stands for the literal 0xFD, 0xFE or 0xFF.

There are two kinds of frame:

- **Write frame.** It carries an address and then data bytes, which are stored at consecutive locations.
- **Read frame.** It carries the marker 0xD0, an address and a length. Its answer is 0xFE, the address, the requested bytes and then 0xFF.

When a complete write frame closes, a one-cycle commit pulse is raised. Downstream buffered regions use it to take the new contents over as a unit.

Writes go to memory as the bytes arrive. Faulty frames are fenced off: no byte after the fault is written, and no commit pulse is raised. The receive side never stalls. When a write and a response fetch want the memory port in the same cycle, the write wins.

Top module: `stuffed_cmd_framer`

## Requirements
- R1: Bytes received outside a frame (before any 0xFE, or after a closing 0xFF) cause no memory write, no commit pulse and no response.
- R2: Inside a frame, 0xFD followed by 0x00, 0x01 or 0x02 is decoded as the single data byte 0xFD, 0xFE or 0xFF respectively.
- R3: In a write frame, the first decoded byte after 0xFE is the start address (any value other than 0xD0). Each following data byte is written to memory at the current address, and the address then advances by one. No response is sent.
- R4: When 0xFF closes a write frame whose address was accepted (even one with no data bytes), frame_done is high for exactly one cycle.
- R5: A read frame is 0xFE, 0xD0, address, length, 0xFF. It is answered with 0xFE, the address, length bytes read from consecutive locations, and 0xFF. In the answer, payload bytes 0xFD/0xFE/0xFF are sent as 0xFD then 0x00/0x01/0x02, and delimiters are sent raw. A length of 0 gives 0xFE, address, 0xFF.
- R6: A 0xFE received inside a frame abandons the partial frame and opens a new one. The abandoned frame gives no commit pulse, but bytes it already wrote remain.
- R7: An escape byte followed by any value other than 0x00–0x02, 0xFE or 0xFF poisons the frame. Neither that byte nor any later byte of the frame is written, and no commit or response follows.
- R8: A frame closed before its header is complete, or a read frame with extra bytes after its length, is dropped: no write, no commit, no response.
- R9: The last writable address is MEM_DEPTH-1. The address stops there instead of wrapping, so further bytes rewrite it (for writes) or repeat it (for reads). A frame whose start address exceeds it is dropped.
- R10: When a received data byte and a response fetch fall in the same cycle, the write takes the memory port. The response waits, loses no byte, and receive bytes are never refused.
- R11: A read frame that closes while a response is still being produced is ignored.
- R12: After reset, tx_valid, mem_we and frame_done are low. While tx_valid is high and tx_ready is low, tx_data and tx_valid hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Response byte offered |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| mem_addr | output | 8 | Memory address (write or read) |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data for mem_addr, same cycle |
| frame_done | output | 1 | One-cycle commit pulse after a valid write frame |

## Verification
A data byte of an incoming write frame and a data fetch for an outgoing read response can both want the single memory port in the same cycle. The bench provokes this in two steps. It first issues a read of eight bytes while tx_ready toggles every cycle. It then streams a ten-byte write frame to a disjoint region, one byte per cycle, so that the write enables land on cycles in which the response is waiting to fetch. The run is judged three ways: every response byte is compared in order against a scoreboard filled from the bench's own memory model, the memory image after the frame must match the model, and the count of write strobes must equal the number of data bytes sent.

// File: rtl/framer_pkg.sv
package framer_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] OPEN_B  = 8'hFE;
    localparam logic [BYTE_W-1:0] CLOSE_B = 8'hFF;
    localparam logic [BYTE_W-1:0] ESC_B   = 8'hFD;
    localparam logic [BYTE_W-1:0] RD_MARK = 8'hD0;

    typedef enum logic [1:0] {EV_OPEN, EV_CLOSE, EV_DATA, EV_BAD} ev_kind_t;

    typedef enum logic [2:0] {
        P_IDLE, P_HDR, P_RADR, P_RLEN, P_RTAIL, P_WDAT, P_DROP
    } pstate_t;

    typedef enum logic [2:0] {R_IDLE, R_OPEN, R_ADR, R_DAT, R_CLOSE} rstate_t;
endpackage

// File: rtl/frm_rx_unstuff.sv
module frm_rx_unstuff
    import framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              ev_valid,
    output ev_kind_t          ev_kind,
    output logic [BYTE_W-1:0] ev_byte
);
    typedef struct packed {
        logic              esc;
        logic              vld;
        ev_kind_t          kind;
        logic [BYTE_W-1:0] b;
    } us_t;

    us_t us_d, us_q;

    always_comb begin
        us_d     = us_q;
        us_d.vld = 1'b0;
        if (rx_valid) begin
            if (rx_data == OPEN_B) begin
                us_d.vld  = 1'b1;
                us_d.kind = EV_OPEN;
                us_d.esc  = 1'b0;
            end else if (rx_data == CLOSE_B) begin
                us_d.vld  = 1'b1;
                us_d.kind = EV_CLOSE;
                us_d.esc  = 1'b0;
            end else if (us_q.esc) begin
                us_d.esc = 1'b0;
                us_d.vld = 1'b1;
                if (rx_data <= 8'h02) begin
                    us_d.kind = EV_DATA;
                    us_d.b    = ESC_B + rx_data;
                end else begin
                    us_d.kind = EV_BAD;
                end
            end else if (rx_data == ESC_B) begin
                us_d.esc = 1'b1;
            end else begin
                us_d.vld  = 1'b1;
                us_d.kind = EV_DATA;
                us_d.b    = rx_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) us_q <= '0;
        else        us_q <= us_d;
    end

    assign ev_valid = us_q.vld;
    assign ev_kind  = us_q.kind;
    assign ev_byte  = us_q.b;

    // R2: an escaped byte decodes only to a reserved value or is flagged bad
    assert_escape_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && us_q.esc && rx_data != OPEN_B && rx_data != CLOSE_B)
        |=> (ev_valid && (ev_kind == EV_BAD || ev_byte >= ESC_B)));
endmodule

// File: rtl/frm_cmd_parser.sv
module frm_cmd_parser
    import framer_pkg::*;
#(
    parameter logic [7:0] LAST_ADDR = 8'h6F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  ev_kind_t          ev_kind,
    input  logic [BYTE_W-1:0] ev_byte,
    input  logic              resp_busy,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_start,
    output logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_len,
    output logic              commit
);
    typedef struct packed {
        pstate_t           st;
        logic [BYTE_W-1:0] ptr;
        logic [BYTE_W-1:0] len;
        logic              commit;
    } ps_t;

    ps_t ps_d, ps_q;

    always_comb begin
        ps_d        = ps_q;
        ps_d.commit = 1'b0;
        wr_en       = 1'b0;
        rd_start    = 1'b0;
        if (ev_valid) begin
            unique case (ev_kind)
                EV_OPEN: ps_d.st = P_HDR;
                EV_BAD:  ps_d.st = (ps_q.st == P_IDLE) ? P_IDLE : P_DROP;
                EV_CLOSE: begin
                    if (ps_q.st == P_WDAT) ps_d.commit = 1'b1;
                    if (ps_q.st == P_RTAIL && !resp_busy) rd_start = 1'b1;
                    ps_d.st = P_IDLE;
                end
                default: begin
                    unique case (ps_q.st)
                        P_HDR: begin
                            if (ev_byte == RD_MARK) begin
                                ps_d.st = P_RADR;
                            end else if (ev_byte > LAST_ADDR) begin
                                ps_d.st = P_DROP;
                            end else begin
                                ps_d.ptr = ev_byte;
                                ps_d.st  = P_WDAT;
                            end
                        end
                        P_RADR: begin
                            if (ev_byte > LAST_ADDR) begin
                                ps_d.st = P_DROP;
                            end else begin
                                ps_d.ptr = ev_byte;
                                ps_d.st  = P_RLEN;
                            end
                        end
                        P_RLEN: begin
                            ps_d.len = ev_byte;
                            ps_d.st  = P_RTAIL;
                        end
                        P_RTAIL: ps_d.st = P_DROP;
                        P_WDAT: begin
                            wr_en    = 1'b1;
                            ps_d.ptr = (ps_q.ptr == LAST_ADDR) ? LAST_ADDR : ps_q.ptr + 8'd1;
                        end
                        default: ps_d.st = ps_q.st;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ps_q <= '{st: P_IDLE, ptr: '0, len: '0, commit: 1'b0};
        else        ps_q <= ps_d;
    end

    assign wr_addr = ps_q.ptr;
    assign wr_data = ev_byte;
    assign rd_addr = ps_q.ptr;
    assign rd_len  = ps_q.len;
    assign commit  = ps_q.commit;

    assert_wr_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr <= LAST_ADDR));

    assert_commit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_bad_escape_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_BAD && ps_q.st != P_IDLE) |=> !wr_en);
endmodule

// File: rtl/frm_resp_seq.sv
module frm_resp_seq
    import framer_pkg::*;
#(
    parameter logic [7:0] LAST_ADDR = 8'h6F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic [BYTE_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_len,
    output logic              busy,
    input  logic              grant,
    output logic [BYTE_W-1:0] fetch_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              off_valid,
    output logic              off_raw,
    output logic [BYTE_W-1:0] off_byte,
    input  logic              off_ready
);
    typedef struct packed {
        rstate_t           st;
        logic [BYTE_W-1:0] ptr;
        logic [BYTE_W-1:0] cnt;
    } rs_t;

    rs_t rs_d, rs_q;

    always_comb begin
        rs_d      = rs_q;
        off_valid = 1'b0;
        off_raw   = 1'b0;
        off_byte  = rs_q.ptr;
        unique case (rs_q.st)
            R_OPEN: begin
                off_valid = 1'b1;
                off_raw   = 1'b1;
                off_byte  = OPEN_B;
            end
            R_ADR: off_valid = 1'b1;
            R_DAT: begin
                off_valid = grant;
                off_byte  = mem_rdata;
            end
            R_CLOSE: begin
                off_valid = 1'b1;
                off_raw   = 1'b1;
                off_byte  = CLOSE_B;
            end
            default: off_valid = 1'b0;
        endcase

        if (rs_q.st == R_IDLE) begin
            if (rd_start) begin
                rs_d.ptr = rd_addr;
                rs_d.cnt = rd_len;
                rs_d.st  = R_OPEN;
            end
        end else if (off_valid && off_ready) begin
            unique case (rs_q.st)
                R_OPEN: rs_d.st = R_ADR;
                R_ADR:  rs_d.st = (rs_q.cnt == '0) ? R_CLOSE : R_DAT;
                R_DAT: begin
                    rs_d.cnt = rs_q.cnt - 8'd1;
                    rs_d.ptr = (rs_q.ptr == LAST_ADDR) ? LAST_ADDR : rs_q.ptr + 8'd1;
                    if (rs_q.cnt == 8'd1) rs_d.st = R_CLOSE;
                end
                default: rs_d.st = R_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '{st: R_IDLE, ptr: '0, cnt: '0};
        else        rs_q <= rs_d;
    end

    assign busy       = (rs_q.st != R_IDLE);
    assign fetch_addr = rs_q.ptr;

    assert_rd_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_q.st == R_DAT) |-> (rs_q.ptr <= LAST_ADDR));
endmodule

// File: rtl/frm_tx_stuff.sv
module frm_tx_stuff
    import framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_raw,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);
    typedef struct packed {
        logic              hold;
        logic [BYTE_W-1:0] data;
        logic              pend;
        logic [BYTE_W-1:0] pb;
    } ts_t;

    ts_t ts_d, ts_q;

    always_comb begin
        ts_d     = ts_q;
        in_ready = !ts_q.hold || (tx_ready && !ts_q.pend);
        if (ts_q.hold && tx_ready) begin
            if (ts_q.pend) begin
                ts_d.data = ts_q.pb;
                ts_d.pend = 1'b0;
            end else begin
                ts_d.hold = 1'b0;
            end
        end
        if (in_valid && in_ready) begin
            ts_d.hold = 1'b1;
            if (!in_raw && in_byte >= ESC_B) begin
                ts_d.data = ESC_B;
                ts_d.pend = 1'b1;
                ts_d.pb   = in_byte - ESC_B;
            end else begin
                ts_d.data = in_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign tx_valid = ts_q.hold;
    assign tx_data  = ts_q.data;

    assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_escape_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && ts_q.pend) |=> (tx_valid && tx_data <= 8'h02));
endmodule

// File: rtl/stuffed_cmd_framer.sv
module stuffed_cmd_framer
    import framer_pkg::*;
#(
    parameter int MEM_DEPTH = 112
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic [7:0] mem_addr,
    output logic [7:0] mem_wdata,
    output logic       mem_we,
    input  logic [7:0] mem_rdata,
    output logic       frame_done
);
    localparam logic [7:0] LAST_ADDR = 8'(MEM_DEPTH - 1);

    logic              ev_valid;
    ev_kind_t          ev_kind;
    logic [BYTE_W-1:0] ev_byte;
    logic              wr_en, rd_start, resp_busy;
    logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_len, fetch_addr;
    logic              off_valid, off_raw, off_ready;
    logic [BYTE_W-1:0] off_byte;

    frm_rx_unstuff u_unstuff (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte)
    );

    frm_cmd_parser #(.LAST_ADDR(LAST_ADDR)) u_parser (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_byte(ev_byte), .resp_busy(resp_busy), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_start(rd_start),
        .rd_addr(rd_addr), .rd_len(rd_len), .commit(frame_done)
    );

    frm_resp_seq #(.LAST_ADDR(LAST_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
        .rd_len(rd_len), .busy(resp_busy), .grant(!wr_en),
        .fetch_addr(fetch_addr), .mem_rdata(mem_rdata), .off_valid(off_valid),
        .off_raw(off_raw), .off_byte(off_byte), .off_ready(off_ready)
    );

    frm_tx_stuff u_stuff (
        .clk(clk), .rst_n(rst_n), .in_valid(off_valid), .in_raw(off_raw),
        .in_byte(off_byte), .in_ready(off_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready)
    );

    // the write path owns the memory port whenever it needs it
    assign mem_we    = wr_en;
    assign mem_wdata = wr_data;
    assign mem_addr  = wr_en ? wr_addr : fetch_addr;
endmodule

// File: tb/stuffed_cmd_framer_test.sv
`timescale 1ns/1ps
module stuffed_cmd_framer_test;
    localparam int MEM_DEPTH = 112;
    localparam logic [7:0] TOP = 8'(MEM_DEPTH - 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_valid, mem_we, frame_done;
    logic [7:0] tx_data, mem_addr, mem_wdata, mem_rdata;
    logic       tx_ready = 1'b0;

    logic [7:0] bmem [0:255];
    logic [7:0] exp_mem [0:255];
    logic [7:0] exp_q [$];
    logic [7:0] dbuf [0:15];
    int n_chk = 0, n_bad = 0;
    int act_commit = 0, exp_commit = 0, act_wr = 0, exp_wr = 0;
    int rmode = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    stuffed_cmd_framer #(.MEM_DEPTH(MEM_DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .frame_done(frame_done)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 8'h00;
        end else if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = bmem[mem_addr];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: drives tx_ready, pops the scoreboard on each handshake
    always @(negedge clk) begin
        logic [7:0] e;
        cyc++;
        tx_ready = (rmode == 0) || (rmode == 1 && cyc[0]);
        if (rst_n) begin
            if (frame_done) act_commit++;
            if (mem_we) act_wr++;
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5/R11 unexpected response byte", tx_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(tx_data == e, "R5 response byte", tx_data, e);
                end
            end
        end
    end

    task automatic put(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pl(input logic [7:0] b);
        if (b >= 8'hFD) begin
            put(8'hFD);
            put(b - 8'hFD);
        end else begin
            put(b);
        end
    endtask

    task automatic push_st(input logic [7:0] b);
        if (b >= 8'hFD) begin
            exp_q.push_back(8'hFD);
            exp_q.push_back(b - 8'hFD);
        end else begin
            exp_q.push_back(b);
        end
    endtask

    task automatic write_frame(input logic [7:0] a, input int n);
        logic [7:0] p;
        put(8'hFE);
        pl(a);
        for (int i = 0; i < n; i++) pl(dbuf[i]);
        put(8'hFF);
        if (a <= TOP) begin
            p = a;
            for (int i = 0; i < n; i++) begin
                exp_mem[p] = dbuf[i];
                exp_wr++;
                if (p < TOP) p = p + 8'd1;
            end
            exp_commit++;
        end
    endtask

    task automatic read_frame(input logic [7:0] a, input logic [7:0] len, input bit expect_it);
        logic [7:0] p;
        if (expect_it) begin
            exp_q.push_back(8'hFE);
            push_st(a);
            p = a;
            for (int i = 0; i < int'(len); i++) begin
                push_st(exp_mem[p]);
                if (p < TOP) p = p + 8'd1;
            end
            exp_q.push_back(8'hFF);
        end
        put(8'hFE);
        put(8'hD0);
        pl(a);
        pl(len);
        put(8'hFF);
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic check_mem(input string req);
        int bad_a = -1;
        for (int a = 0; a < 256; a++)
            if (bad_a < 0 && bmem[a] !== exp_mem[a]) bad_a = a;
        if (bad_a < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, {bad_a[7:0], bmem[bad_a]}, {bad_a[7:0], exp_mem[bad_a]});
    endtask

    task automatic check_counts(input string req);
        chk(act_commit == exp_commit, {req, " commit count"}, act_commit, exp_commit);
        chk(act_wr == exp_wr, {req, " write count"}, act_wr, exp_wr);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!tx_valid && !mem_we && !frame_done, "R12 reset outputs", {tx_valid, mem_we, frame_done}, 0);

        // R2 R3 R4: escaped data in a write frame
        dbuf[0] = 8'h30; dbuf[1] = 8'hFF;
        write_frame(8'h00, 2);
        drain("R3 idle");
        check_mem("R2 R3 write content");
        check_counts("R4");

        // R5: read back with stuffed response
        read_frame(8'h00, 8'd2, 1'b1);
        drain("R5 response complete");

        // R2 R5: all reserved values as payload, with tx backpressure
        rmode = 1;
        dbuf[0] = 8'hFD; dbuf[1] = 8'hFE; dbuf[2] = 8'hFF;
        write_frame(8'h30, 3);
        read_frame(8'h30, 8'd3, 1'b1);
        drain("R2 reserved payload response");
        rmode = 0;
        check_mem("R2 reserved payload memory");

        // R1: bytes outside frames
        put(8'h44); put(8'h12); put(8'hFF); put(8'h07);
        repeat (4) @(negedge clk);
        check_counts("R1 outside bytes");

        // R6: reopen mid-frame
        put(8'hFE); put(8'h20); put(8'h11);
        put(8'hFE); put(8'h21); put(8'h22); put(8'hFF);
        exp_mem[8'h20] = 8'h11; exp_mem[8'h21] = 8'h22;
        exp_wr += 2; exp_commit += 1;
        repeat (4) @(negedge clk);
        check_mem("R6 reopen memory");
        check_counts("R6");

        // R7: bad escape poisons the rest of the frame
        put(8'hFE); put(8'h10); put(8'hAA); put(8'hFD); put(8'h05); put(8'hBB); put(8'hFF);
        exp_mem[8'h10] = 8'hAA; exp_wr += 1;
        put(8'hFE); put(8'hD0); put(8'hFD); put(8'h07); put(8'h02); put(8'hFF);
        repeat (10) @(negedge clk);
        check_mem("R7 bad escape memory");
        check_counts("R7");
        chk(exp_q.size() == 0, "R7 no response", exp_q.size(), 0);

        // R8: incomplete or overlong headers
        put(8'hFE); put(8'hFF);
        put(8'hFE); put(8'hD0); put(8'h05); put(8'hFF);
        put(8'hFE); put(8'hD0); put(8'h05); put(8'h02); put(8'h09); put(8'hFF);
        repeat (10) @(negedge clk);
        check_counts("R8");

        // R9: saturation at the last address and out-of-range starts
        dbuf[0] = 8'h01; dbuf[1] = 8'h02; dbuf[2] = 8'h03;
        write_frame(TOP - 8'd1, 3);
        read_frame(TOP - 8'd1, 8'd4, 1'b1);
        drain("R9 saturated read");
        dbuf[0] = 8'h55;
        write_frame(8'h80, 1);
        read_frame(8'h90, 8'd2, 1'b0);
        repeat (10) @(negedge clk);
        check_mem("R9 saturated memory");
        check_counts("R9");

        // R5: zero-length read
        read_frame(8'h05, 8'd0, 1'b1);
        drain("R5 zero length");

        // R10: write bytes collide with response fetches
        for (int i = 0; i < 8; i++) dbuf[i] = 8'(8'hA0 + i * 3);
        write_frame(8'h40, 8);
        repeat (4) @(negedge clk);
        rmode = 1;
        read_frame(8'h40, 8'd8, 1'b1);
        for (int i = 0; i < 10; i++) dbuf[i] = 8'(8'h60 + i);
        write_frame(8'h50, 10);
        drain("R10 response during writes");
        rmode = 0;
        check_mem("R10 memory during response");
        check_counts("R10");

        // R11: second read while response stalled
        rmode = 2;
        read_frame(8'h40, 8'd3, 1'b1);
        read_frame(8'h00, 8'd2, 1'b0);
        repeat (20) @(negedge clk);
        rmode = 0;
        drain("R11 only first response");
        check_counts("R11");

        finish_run();
    end
endmodule